// File: doc/BRIEF.md
# Serially Configured Correlated-Double-Sampling ADC Controller

This block drives a 16-bit imaging analog-to-digital converter that is set up over a three-wire serial port and then run in single-channel sample-and-hold mode. After reset it writes a fixed list of 16-bit configuration words to the converter. Each write is one frame on a serial clock, a load strobe and a data line. When the last word has gone out, it raises a configuration-done flag, and the detector readout must not be enabled before that flag is high.

Once configuration is done, the block runs two free-running sampling clocks of equal frequency (1 MHz with the default parameters) from a single counter. These are the data-level sample clock and the conversion clock. The conversion clock lags the sample clock by a quarter period. The converter returns each result one byte at a time: the high byte while the conversion clock is high, and the low byte after it falls. The block captures both bytes and presents the joined 16-bit pixel word with a one-cycle valid pulse.

Top module: `cds_adc_ctrl`

## Requirements
- R1: While reset is held, the load strobe is high, the serial clock and data are low, and both sampling clocks, the done flag and the pixel valid are all low.
- R2: Each register write is one frame. The load strobe is low for the whole frame, and the frame holds exactly 16 serial-clock rising edges, most significant bit first. Data changes only while the serial clock is low and is stable for the whole of each high phase.
- R3: Exactly NUM_REGS frames are sent, in index order 0, 1, 2 and so on. Entry k of the configuration table is bits [16k+15:16k] of the table parameter.
- R4: The done flag rises only after the load strobe of the final frame has returned high. It then stays high, with the load strobe held high and the serial clock held low.
- R5: Both sampling clocks stay low until the done flag is high. After that, the data-level sample clock has a period of PERIOD system cycles and is high for PERIOD/2 of them.
- R6: The conversion clock is the data-level sample clock delayed by PERIOD/4 system cycles (a 90 degree lag). It is therefore low at every rising edge of the sample clock.
- R7: The high byte is the one present on the byte input in the first cycle after the conversion clock rises. The low byte is the one present in the first cycle after it falls. The pixel word is {high, low} and is output with a single-cycle valid pulse one system clock after the low byte is captured.
- R8: The pixel word output holds its value in every cycle in which no new valid pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_byte_i | input | 8 | Byte-wide converter result bus |
| ser_clk_o | output | 1 | Serial configuration clock |
| ser_load_o | output | 1 | Serial load strobe, low during a frame |
| ser_data_o | output | 1 | Serial configuration data |
| cfg_done_o | output | 1 | High once all configuration words are written |
| lvl_smp_clk_o | output | 1 | Data-level sample clock |
| conv_clk_o | output | 1 | Conversion clock, quarter period behind the sample clock |
| pix_data_o | output | 16 | Reassembled pixel word |
| pix_valid_o | output | 1 | One-cycle pulse when pix_data_o is new |

## Verification
The hardest situation to reach from the ports is byte capture lined up with the conversion clock. The converter places the correct byte on the bus only after it has seen the clock edge. The bench solves this with a behavioural converter model that watches the conversion clock at every falling system edge. It drives the high byte of a fresh sample while that clock is high and the low byte while it is low, so the capture cycle and the edge-selected byte are both tested for real. The sample values include words whose bytes are 00 and FF, so a swapped or shifted byte is visible. The serial side is checked by decoding every frame against the table. The quarter-period lag is measured as the distance in cycles between the rising edges of the two clocks.

// File: rtl/cds_pkg.sv
package cds_pkg;

    localparam int unsigned FRAME_BITS = 16;

    typedef logic [FRAME_BITS-1:0] cfg_word_t;

    typedef enum logic [1:0] {
        LD_GAP   = 2'd0,
        LD_FRAME = 2'd1,
        LD_DONE  = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } pix_word_t;

    typedef struct packed {
        logic lvl;
        logic conv;
    } qclk_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cds_cfg_loader.sv
module cds_cfg_loader
    import cds_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 4,
    parameter int unsigned SCLK_HALF = 2,
    parameter int unsigned GAP_LEN   = 4,
    parameter logic [NUM_REGS*FRAME_BITS-1:0] CFG_TABLE = '0
) (
    input  logic clk,
    input  logic rst,
    output logic ser_clk,
    output logic ser_load,
    output logic ser_data,
    output logic done
);

    localparam int unsigned BIT_PH = 2 * SCLK_HALF;
    localparam int unsigned PH_MAX = max_u(BIT_PH, GAP_LEN);
    localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
    localparam int unsigned IDX_W  = $clog2(NUM_REGS + 1);
    localparam int unsigned BIT_W  = $clog2(FRAME_BITS);

    ld_state_e        state;
    logic [PH_W-1:0]  ph;
    logic [BIT_W-1:0] bit_idx;
    logic [IDX_W-1:0] idx;
    cfg_word_t        cur_word;

    always_comb begin
        cur_word = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (idx == IDX_W'(k)) cur_word = CFG_TABLE[k*FRAME_BITS +: FRAME_BITS];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LD_GAP;
            ph      <= '0;
            bit_idx <= '0;
            idx     <= '0;
            done    <= 1'b0;
        end else begin
            case (state)
                LD_GAP: begin
                    if (ph == PH_W'(GAP_LEN - 1)) begin
                        ph <= '0;
                        if (idx == IDX_W'(NUM_REGS)) begin
                            state <= LD_DONE;
                            done  <= 1'b1;
                        end else begin
                            state   <= LD_FRAME;
                            bit_idx <= '0;
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                LD_FRAME: begin
                    if (ph == PH_W'(BIT_PH - 1)) begin
                        ph <= '0;
                        if (bit_idx == BIT_W'(FRAME_BITS - 1)) begin
                            state <= LD_GAP;
                            idx   <= idx + 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: begin
                    state <= LD_DONE;
                end
            endcase
        end
    end

    // Serial clock is low for the first half of every bit slot; the bit
    // index advances together with the falling edge at the slot end.
    assign ser_clk  = (state == LD_FRAME) && (ph >= PH_W'(SCLK_HALF));
    assign ser_load = (state != LD_FRAME);
    assign ser_data = (state == LD_FRAME) ? cur_word[BIT_W'(FRAME_BITS - 1) - bit_idx] : 1'b0;

endmodule

// File: rtl/cds_quad_clk.sv
module cds_quad_clk
    import cds_pkg::*;
#(
    parameter int unsigned PERIOD = 100
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    output qclk_t qclk
);

    localparam int unsigned CNT_W   = $clog2(PERIOD);
    localparam int unsigned HALF    = PERIOD / 2;
    localparam int unsigned QUARTER = PERIOD / 4;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_lag;

    always_comb begin
        if (cnt >= CNT_W'(QUARTER)) cnt_lag = cnt - CNT_W'(QUARTER);
        else                        cnt_lag = cnt + CNT_W'(PERIOD - QUARTER);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            qclk <= '0;
        end else if (en) begin
            cnt       <= (cnt == CNT_W'(PERIOD - 1)) ? '0 : cnt + 1'b1;
            qclk.lvl  <= (cnt < CNT_W'(HALF));
            qclk.conv <= (cnt_lag < CNT_W'(HALF));
        end
    end

endmodule

// File: rtl/cds_byte_merge.sv
module cds_byte_merge
    import cds_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       conv_clk,
    input  logic [7:0] byte_i,
    output pix_word_t  word_o,
    output logic       valid_o
);

    logic       conv_prev;
    logic       have_hi;
    logic       lo_ready;
    pix_word_t  stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_prev <= 1'b0;
            have_hi   <= 1'b0;
            lo_ready  <= 1'b0;
            stage     <= '0;
            word_o    <= '0;
            valid_o   <= 1'b0;
        end else begin
            conv_prev <= conv_clk;
            lo_ready  <= 1'b0;
            valid_o   <= 1'b0;
            if (conv_clk && !conv_prev) begin
                stage.hi <= byte_i;
                have_hi  <= 1'b1;
            end
            if (!conv_clk && conv_prev && have_hi) begin
                stage.lo <= byte_i;
                lo_ready <= 1'b1;
                have_hi  <= 1'b0;
            end
            if (lo_ready) begin
                word_o  <= stage;
                valid_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cds_adc_ctrl.sv
module cds_adc_ctrl
    import cds_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 4,
    parameter int unsigned SCLK_HALF = 2,
    parameter int unsigned GAP_LEN   = 4,
    parameter int unsigned PERIOD    = 100,
    parameter logic [NUM_REGS*16-1:0] CFG_TABLE = 64'h00C8_2F10_4A07_9003
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  adc_byte_i,
    output logic        ser_clk_o,
    output logic        ser_load_o,
    output logic        ser_data_o,
    output logic        cfg_done_o,
    output logic        lvl_smp_clk_o,
    output logic        conv_clk_o,
    output logic [15:0] pix_data_o,
    output logic        pix_valid_o
);

    qclk_t     qclk;
    pix_word_t word;

    cds_cfg_loader #(
        .NUM_REGS  (NUM_REGS),
        .SCLK_HALF (SCLK_HALF),
        .GAP_LEN   (GAP_LEN),
        .CFG_TABLE (CFG_TABLE)
    ) i_loader (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (ser_clk_o),
        .ser_load (ser_load_o),
        .ser_data (ser_data_o),
        .done     (cfg_done_o)
    );

    cds_quad_clk #(
        .PERIOD (PERIOD)
    ) i_quad (
        .clk  (clk),
        .rst  (rst),
        .en   (cfg_done_o),
        .qclk (qclk)
    );

    cds_byte_merge i_merge (
        .clk      (clk),
        .rst      (rst),
        .conv_clk (qclk.conv),
        .byte_i   (adc_byte_i),
        .word_o   (word),
        .valid_o  (pix_valid_o)
    );

    assign lvl_smp_clk_o = qclk.lvl;
    assign conv_clk_o    = qclk.conv;
    assign pix_data_o    = word;

endmodule

// File: rtl/cds_adc_checker.sv
module cds_adc_checker (
    input logic        clk,
    input logic        rst,
    input logic        ser_clk_o,
    input logic        ser_load_o,
    input logic        ser_data_o,
    input logic        cfg_done_o,
    input logic        lvl_smp_clk_o,
    input logic        conv_clk_o,
    input logic [15:0] pix_data_o,
    input logic        pix_valid_o
);

    assert_idle_clock_low_R2: assert property (@(posedge clk) disable iff (rst)
        ser_load_o |-> !ser_clk_o);

    assert_data_stable_high_R2: assert property (@(posedge clk) disable iff (rst)
        (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o));

    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_done_o |=> cfg_done_o);

    assert_done_port_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_done_o |-> (ser_load_o && !ser_clk_o));

    assert_clocks_gated_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg_done_o |-> (!lvl_smp_clk_o && !conv_clk_o));

    assert_conv_lags_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(lvl_smp_clk_o) |-> !conv_clk_o);

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        pix_valid_o |=> !pix_valid_o);

    assert_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !pix_valid_o |-> $stable(pix_data_o));

endmodule

bind cds_adc_ctrl cds_adc_checker i_chk (
    .clk           (clk),
    .rst           (rst),
    .ser_clk_o     (ser_clk_o),
    .ser_load_o    (ser_load_o),
    .ser_data_o    (ser_data_o),
    .cfg_done_o    (cfg_done_o),
    .lvl_smp_clk_o (lvl_smp_clk_o),
    .conv_clk_o    (conv_clk_o),
    .pix_data_o    (pix_data_o),
    .pix_valid_o   (pix_valid_o)
);

// File: tb/test_cds_adc_ctrl.sv
`timescale 1ns/1ps
module test_cds_adc_ctrl;

    localparam int NREG = 4;
    localparam int PER  = 100;
    localparam int QTR  = PER / 4;
    localparam logic [NREG*16-1:0] TABLE = 64'hFF01_8000_0A5C_1234;
    localparam int WANT_PIX = 30;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  adc_byte_i = 8'h00;
    logic        ser_clk_o, ser_load_o, ser_data_o, cfg_done_o;
    logic        lvl_smp_clk_o, conv_clk_o, pix_valid_o;
    logic [15:0] pix_data_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cds_adc_ctrl #(
        .NUM_REGS  (NREG),
        .SCLK_HALF (2),
        .GAP_LEN   (4),
        .PERIOD    (PER),
        .CFG_TABLE (TABLE)
    ) i_cds_adc_ctrl (
        .clk           (clk),
        .rst           (rst),
        .adc_byte_i    (adc_byte_i),
        .ser_clk_o     (ser_clk_o),
        .ser_load_o    (ser_load_o),
        .ser_data_o    (ser_data_o),
        .cfg_done_o    (cfg_done_o),
        .lvl_smp_clk_o (lvl_smp_clk_o),
        .conv_clk_o    (conv_clk_o),
        .pix_data_o    (pix_data_o),
        .pix_valid_o   (pix_valid_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] sample_val(input int n);
        if (n == 1) return 16'hFF00;
        if (n == 2) return 16'h00FF;
        return 16'((n * 16'h1357) + 16'h0A5C);
    endfunction

    // reference model state
    int          cyc = 0;
    bit          pv_sclk, pv_sload = 1'b1, pv_sdata, pv_done, pv_conv, pv_lvl;
    logic [15:0] shreg = '0;
    int          nbits = 0;
    int          frames = 0;
    int          t_done = -1;
    int          lvl_rise_prev = -1;
    int          first_lvl_rise = -1;
    bit          lag_checked = 0;
    int          period_checks = 0;
    int          nsamp = 0;
    logic [15:0] cur_samp = '0;
    bit          hi_seen = 0;
    int          pend_cd = 0;
    logic [15:0] exp_word = '0;
    logic [15:0] last_word = '0;
    int          pix_seen = 0;
    bit          run = 0;

    always @(negedge clk) begin
        if (run) begin
            int  j;
            bit  e_lvl, e_conv, e_valid;
            cyc++;

            // serial frame decoding, R2 and R3
            if (!ser_load_o && ser_clk_o && !pv_sclk) begin
                shreg = {shreg[14:0], ser_data_o};
                nbits++;
            end
            if (ser_clk_o && pv_sclk)
                check(ser_data_o == pv_sdata, "R2 data stable in high phase", ser_data_o, pv_sdata);
            if (ser_load_o && !pv_sload) begin
                check(nbits == 16, "R2 bits per frame", nbits, 16);
                if (frames < NREG)
                    check(shreg == TABLE[frames*16 +: 16], "R3 frame word", shreg, TABLE[frames*16 +: 16]);
                else
                    check(0, "R3 extra frame", frames, NREG);
                check(!cfg_done_o, "R4 done before final strobe return", cfg_done_o, 0);
                frames++;
                nbits = 0;
            end
            if (cfg_done_o && !pv_done)
                check(frames == NREG, "R3 R4 frame count at done", frames, NREG);
            if (pv_done)
                check(cfg_done_o && ser_load_o && !ser_clk_o, "R4 quiet after done",
                      {cfg_done_o, ser_load_o, ser_clk_o}, 3'b110);

            // quadrature clock model, R5 and R6
            if (cfg_done_o) t_done++;
            j = t_done - 1;
            e_lvl  = cfg_done_o && (j >= 0) && ((j % PER) < PER / 2);
            e_conv = cfg_done_o && (j >= QTR) && (((j - QTR) % PER) < PER / 2);
            check(lvl_smp_clk_o == e_lvl, "R5 sample clock level", lvl_smp_clk_o, e_lvl);
            check(conv_clk_o == e_conv, "R6 conversion clock level", conv_clk_o, e_conv);
            if (lvl_smp_clk_o && !pv_lvl) begin
                if (lvl_rise_prev >= 0 && period_checks < 5) begin
                    check(cyc - lvl_rise_prev == PER, "R5 period", cyc - lvl_rise_prev, PER);
                    period_checks++;
                end
                if (first_lvl_rise < 0) first_lvl_rise = cyc;
                lvl_rise_prev = cyc;
            end
            if (conv_clk_o && !pv_conv && !lag_checked && first_lvl_rise >= 0) begin
                check(cyc - first_lvl_rise == QTR, "R6 quarter-period lag", cyc - first_lvl_rise, QTR);
                lag_checked = 1;
            end

            // pixel reassembly model, R7 and R8
            e_valid = 0;
            if (pend_cd > 0) begin
                pend_cd--;
                if (pend_cd == 0) e_valid = 1;
            end
            check(pix_valid_o == e_valid, "R7 valid timing", pix_valid_o, e_valid);
            if (e_valid) begin
                check(pix_data_o == exp_word, "R7 reassembled word", pix_data_o, exp_word);
                last_word = exp_word;
                pix_seen++;
            end else begin
                check(pix_data_o == last_word, "R8 word held", pix_data_o, last_word);
            end
            if (conv_clk_o && !pv_conv) begin
                nsamp++;
                cur_samp = sample_val(nsamp);
                hi_seen = 1;
            end
            if (!conv_clk_o && pv_conv && hi_seen) begin
                pend_cd = 2;
                exp_word = cur_samp;
                hi_seen = 0;
            end
            adc_byte_i = conv_clk_o ? cur_samp[15:8] : cur_samp[7:0];

            pv_sclk  = ser_clk_o;
            pv_sload = ser_load_o;
            pv_sdata = ser_data_o;
            pv_done  = cfg_done_o;
            pv_conv  = conv_clk_o;
            pv_lvl   = lvl_smp_clk_o;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(ser_load_o == 1'b1, "R1 load strobe high", ser_load_o, 1);
        check(ser_clk_o == 1'b0, "R1 serial clock low", ser_clk_o, 0);
        check(ser_data_o == 1'b0, "R1 serial data low", ser_data_o, 0);
        check(cfg_done_o == 1'b0, "R1 done low", cfg_done_o, 0);
        check(lvl_smp_clk_o == 1'b0 && conv_clk_o == 1'b0, "R1 sample clocks low",
              {lvl_smp_clk_o, conv_clk_o}, 0);
        check(pix_valid_o == 1'b0, "R1 valid low", pix_valid_o, 0);
        rst = 1'b0;
        run = 1;
        while (pix_seen < WANT_PIX && cyc < WATCHDOG) @(posedge clk);
        @(negedge clk);
        run = 0;
        if (cyc >= WATCHDOG) check(0, "watchdog expired", cyc, WATCHDOG);
        check(frames == NREG, "R3 total frames", frames, NREG);
        check(lag_checked, "R6 lag measured", lag_checked, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule